// File: doc/BRIEF.md
# Reed-Solomon Parity Encoder

This block produces systematic Reed-Solomon codewords over GF(256) with 8-bit symbols and sixteen check symbols, as used in digital broadcast channel coding. Each enabled clock it accepts one message symbol and forwards it to the output unchanged. At the same time, a sixteen-stage feedback shift register divides the message by the generator polynomial. The generator polynomial has the roots alpha^0 through alpha^15, taken in the field built from x^8+x^4+x^3+x^2+1.

The block has no length setting. An external sequencer holds the `absorb` line high for the message symbols and then low for sixteen enabled cycles. While `absorb` is low, the block emits the remainder with the highest-order symbol first. The register chain fills with zeros as the symbols leave, so the next block can begin on the following enabled cycle. Any shortened code with sixteen check symbols works in this way, up to a total length of 255.

Top module: `rs_parity_encoder`

## Requirements
- R1: Symbols are 8 bits wide and all arithmetic is in GF(256) reduced by x^8+x^4+x^3+x^2+1 (bit pattern 0x11D).
- R2: Each emitted codeword evaluates to zero at alpha^j for every j from 0 to 15, where alpha = 0x02 and the first emitted symbol is the highest-degree coefficient.
- R3: On an enabled cycle with `absorb` high, the input symbol appears unchanged on `sym_out` after that edge, so the latency is one enabled cycle.
- R4: On an enabled cycle with `absorb` low, `sym_out` takes the highest-order remainder register. Over sixteen such cycles the remainder leaves highest-order first, and `sym_in` is ignored.
- R5: After sixteen consecutive enabled cycles with `absorb` low, every remainder register is zero. A later block therefore gets the same check symbols as it would directly after reset.
- R6: While `clk_en` is low, no register changes and `sym_out` holds. Inserting disabled cycles anywhere in a block leaves its check symbols unchanged.
- R7: The reset is synchronous and active low (`rst_n`). It clears `sym_out` and the remainder registers, and this includes a reset in the middle of a block.
- R8: The message length is set only by the duration of `absorb`. Any length from 1 to 239 symbols gives a valid codeword.
- R9: The first message symbol of the next block may be presented on the enabled cycle right after the sixteenth check-symbol cycle.
- R10: An all-zero message yields sixteen zero check symbols.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_en | input | 1 | Enable for every register, active high |
| absorb | input | 1 | High: take a message symbol; low: emit a check symbol |
| sym_in | input | 8 | Message symbol input |
| sym_out | output | 8 | Codeword symbol output, registered |

## Verification
The bench uses the default parameters: 8-bit symbols, sixteen check symbols, field polynomial 0x11D and first root alpha^0. With these values every legal length from 1 to 239 message symbols can be reached. The bench checks message lengths of 1, 5, 50, 188 and 239, and it runs some blocks back to back. It does not predict the check symbols. Instead it evaluates all sixteen syndromes of each captured codeword in its own field arithmetic. To test enable gaps, flushing and mid-block reset, it compares the check symbols of a repeated 188-symbol message across those conditions.

// File: rtl/rs_enc_pkg.sv
// Package: shared mode type and generic GF(2^w) multiply for the RS encoder.
// Assumes symbol widths of at most 16 bits.
package rs_enc_pkg;

    typedef enum logic {
        MODE_SHIFT  = 1'b0,
        MODE_ABSORB = 1'b1
    } rs_mode_e;

    // Shift-and-add multiply in GF(2^w), reducing by poly whenever bit w is set.
    function automatic logic [15:0] gf_mul(input logic [15:0] a,
                                           input logic [15:0] b,
                                           input logic [16:0] poly,
                                           input int unsigned w);
        logic [16:0] acc;
        logic [16:0] sh;
        acc = '0;
        sh  = {1'b0, a};
        for (int unsigned i = 0; i < 16; i++) begin
            if (i < w) begin
                if (b[i[3:0]]) acc = acc ^ sh;
                sh = sh << 1;
                if (sh[w[4:0]]) sh = sh ^ poly;
            end
        end
        return acc[15:0];
    endfunction

endpackage

// File: rtl/rs_gf_cmul.sv
// Module: multiplies a symbol by a constant field element.
// Assumes COEF is fixed at elaboration, so the logic reduces to an XOR network.
module rs_gf_cmul #(
    parameter int unsigned           SYM_W      = 8,
    parameter logic [SYM_W:0]        FIELD_POLY = 9'h11D,
    parameter logic [SYM_W-1:0]      COEF       = 8'h01
) (
    input  logic [SYM_W-1:0] a,
    output logic [SYM_W-1:0] y
);

    // Constant product.
    assign y = SYM_W'(rs_enc_pkg::gf_mul(16'(a), 16'(COEF), 17'(FIELD_POLY), SYM_W));

endmodule

// File: rtl/rs_parity_lfsr.sv
// Module: remainder register chain dividing the message by the generator polynomial.
// The generator coefficients are computed at elaboration from FIELD_POLY and FIRST_ROOT.
// In shift mode the feedback is zero, so the chain moves toward par_top and fills with zeros.
module rs_parity_lfsr #(
    parameter int unsigned      SYM_W      = 8,
    parameter int unsigned      NPAR       = 16,
    parameter logic [SYM_W:0]   FIELD_POLY = 9'h11D,
    parameter int unsigned      FIRST_ROOT = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic             absorb,
    input  logic [SYM_W-1:0] sym_in,
    output logic [SYM_W-1:0] par_top
);

    function automatic logic [SYM_W-1:0] fmul(input logic [SYM_W-1:0] a,
                                              input logic [SYM_W-1:0] b);
        return SYM_W'(rs_enc_pkg::gf_mul(16'(a), 16'(b), 17'(FIELD_POLY), SYM_W));
    endfunction

    // Builds the low coefficients of prod (x + alpha^(FIRST_ROOT+i)); the top one is 1.
    function automatic logic [NPAR-1:0][SYM_W-1:0] gen_poly();
        logic [NPAR:0][SYM_W-1:0] g;
        logic [SYM_W-1:0]         root;
        g    = '0;
        g[0] = SYM_W'(1);
        root = SYM_W'(1);
        for (int unsigned r = 0; r < FIRST_ROOT; r++) root = fmul(root, SYM_W'(2));
        for (int unsigned i = 0; i < NPAR; i++) begin
            for (int unsigned j = NPAR; j > 0; j--) g[j] = g[j-1] ^ fmul(g[j], root);
            g[0] = fmul(g[0], root);
            root = fmul(root, SYM_W'(2));
        end
        return g[NPAR-1:0];
    endfunction

    localparam logic [NPAR-1:0][SYM_W-1:0] GEN = gen_poly();

    logic [SYM_W-1:0] par  [NPAR];
    logic [SYM_W-1:0] nxt  [NPAR];
    logic [SYM_W-1:0] prod [NPAR];
    logic [SYM_W-1:0] fb;

    // Feedback: input plus top register when absorbing, zero when shifting.
    always_comb begin
        fb = (rs_enc_pkg::rs_mode_e'(absorb) == rs_enc_pkg::MODE_ABSORB)
             ? (sym_in ^ par[NPAR-1]) : '0;
    end

    generate
        for (genvar s = 0; s < NPAR; s++) begin : g_stage
            rs_gf_cmul #(
                .SYM_W      (SYM_W),
                .FIELD_POLY (FIELD_POLY),
                .COEF       (GEN[s])
            ) u_mul (
                .a (fb),
                .y (prod[s])
            );
            if (s == 0) begin : g_first
                assign nxt[s] = prod[s];
            end else begin : g_rest
                assign nxt[s] = par[s-1] ^ prod[s];
            end
        end
    endgenerate

    // Remainder registers: sync clear, advance on enabled cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NPAR; i++) par[i] <= '0;
        end else if (clk_en) begin
            for (int i = 0; i < NPAR; i++) par[i] <= nxt[i];
        end
    end

    assign par_top = par[NPAR-1];

endmodule

// File: rtl/rs_out_stage.sv
// Module: registered output select, message symbol or top remainder symbol.
// Assumes par_top is the value before the current edge's shift.
module rs_out_stage #(
    parameter int unsigned SYM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic             absorb,
    input  logic [SYM_W-1:0] sym_in,
    input  logic [SYM_W-1:0] par_top,
    output logic [SYM_W-1:0] sym_out
);

    rs_enc_pkg::rs_mode_e mode;
    assign mode = rs_enc_pkg::rs_mode_e'(absorb);

    // Output register: pass message in absorb mode, emit remainder otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      sym_out <= '0;
        else if (clk_en) sym_out <= (mode == rs_enc_pkg::MODE_ABSORB) ? sym_in : par_top;
    end

endmodule

// File: rtl/rs_parity_encoder.sv
// Module: top of the systematic RS encoder; message passes through, remainder follows.
// Assumes an external sequencer holds absorb low for NPAR enabled cycles after each message.
module rs_parity_encoder #(
    parameter int unsigned    SYM_W      = 8,
    parameter int unsigned    NPAR       = 16,
    parameter logic [SYM_W:0] FIELD_POLY = 9'h11D,
    parameter int unsigned    FIRST_ROOT = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic             absorb,
    input  logic [SYM_W-1:0] sym_in,
    output logic [SYM_W-1:0] sym_out
);

    logic [SYM_W-1:0] top_par;

    rs_parity_lfsr #(
        .SYM_W      (SYM_W),
        .NPAR       (NPAR),
        .FIELD_POLY (FIELD_POLY),
        .FIRST_ROOT (FIRST_ROOT)
    ) u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clk_en  (clk_en),
        .absorb  (absorb),
        .sym_in  (sym_in),
        .par_top (top_par)
    );

    rs_out_stage #(
        .SYM_W (SYM_W)
    ) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .clk_en  (clk_en),
        .absorb  (absorb),
        .sym_in  (sym_in),
        .par_top (top_par),
        .sym_out (sym_out)
    );

endmodule

// File: rtl/rs_parity_encoder_chk.sv
// Module: protocol checker bound to the encoder top.
// Assumes the top exposes top_par, the remainder register feeding the output select.
module rs_parity_encoder_chk #(
    parameter int unsigned SYM_W = 8,
    parameter int unsigned NPAR  = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clk_en,
    input logic             absorb,
    input logic [SYM_W-1:0] sym_in,
    input logic [SYM_W-1:0] sym_out,
    input logic [SYM_W-1:0] par_top
);

    localparam int unsigned RUN_W = $clog2(NPAR + 1);
    logic [RUN_W-1:0] shift_run;

    // Counts enabled shift cycles since the last absorb cycle, saturating at NPAR.
    always_ff @(posedge clk) begin
        if (!rst_n)           shift_run <= '0;
        else if (clk_en) begin
            if (absorb)                       shift_run <= '0;
            else if (shift_run < RUN_W'(NPAR)) shift_run <= shift_run + 1'b1;
        end
    end

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && absorb) |=> (sym_out == $past(sym_in))); // R3

    AST_SHIFT_EMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !absorb) |=> (sym_out == $past(par_top))); // R4

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en) |=> $stable(sym_out)); // R6

    AST_FLUSHED_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_run == RUN_W'(NPAR)) |-> (par_top == '0)); // R5

    AST_FLUSHED_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !absorb && shift_run == RUN_W'(NPAR)) |=> (sym_out == '0)); // R5

endmodule

bind rs_parity_encoder rs_parity_encoder_chk #(
    .SYM_W (SYM_W),
    .NPAR  (NPAR)
) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .clk_en  (clk_en),
    .absorb  (absorb),
    .sym_in  (sym_in),
    .sym_out (sym_out),
    .par_top (top_par)
);

// File: tb/test_rs_parity_encoder.sv
module test_rs_parity_encoder;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 16;

    logic       clk    = 1'b0;
    logic       rst_n  = 1'b0;
    logic       clk_en = 1'b0;
    logic       absorb = 1'b0;
    logic [7:0] sym_in = 8'h00;
    wire  [7:0] sym_out;

    rs_parity_encoder i_rs_parity_encoder (
        .clk     (clk),
        .rst_n   (rst_n),
        .clk_en  (clk_en),
        .absorb  (absorb),
        .sym_in  (sym_in),
        .sym_out (sym_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct packed {
        logic       is_par;
        logic [7:0] sym;
    } exp_t;

    exp_t       exp_q[$];
    exp_t       e;
    int         checks = 0;
    int         errors = 0;
    logic       en_seen = 1'b0;
    logic       rst_seen = 1'b0;
    logic [7:0] prev_out = 8'h00;
    logic [7:0] cw[$];
    logic [7:0] last_par [NP];
    logic [7:0] ref_par  [NP];
    int         par_cnt = 0;
    int         blocks_done = 0;

    // Independent field multiply, reduction by 0x11D.
    function automatic logic [7:0] bmul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] r;
        logic [7:0] x;
        r = 8'h00;
        x = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) r = r ^ x;
            x = x[7] ? ((x << 1) ^ 8'h1D) : (x << 1);
        end
        return r;
    endfunction

    function automatic logic [7:0] pat(input int i, input int seed);
        return 8'((i * 37 + seed * 91 + 13) ^ (i >> 2));
    endfunction

    // Evaluate the captured codeword at alpha^0..alpha^15.
    task automatic check_syndromes();
        logic [7:0] root;
        logic [7:0] s;
        int         bad_j;
        logic [7:0] bad_s;
        bad_j = -1;
        bad_s = 8'h00;
        root  = 8'h01;
        for (int j = 0; j < NP; j++) begin
            s = 8'h00;
            for (int i = 0; i < cw.size(); i++) s = bmul(s, root) ^ cw[i];
            if (s != 8'h00 && bad_j < 0) begin bad_j = j; bad_s = s; end
            root = bmul(root, 8'h02);
        end
        checks++;
        if (bad_j >= 0) begin
            errors++;
            $display("FAIL R1 R2 R4: syndrome at alpha^%0d of %0d-symbol codeword actual=%02h expected=00",
                     bad_j, cw.size(), bad_s);
        end
    endtask

    always @(posedge clk) begin
        en_seen  <= clk_en && rst_n;
        rst_seen <= rst_n;
    end

    // Monitor: pops expected items after each enabled edge and checks idle hold.
    always @(negedge clk) begin
        if (!rst_n) begin
            cw.delete();
            par_cnt = 0;
        end else if (en_seen) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R3: output %02h with no expected item, expected none", sym_out);
            end else begin
                e = exp_q.pop_front();
                cw.push_back(sym_out);
                if (!e.is_par) begin
                    checks++;
                    if (sym_out !== e.sym) begin
                        errors++;
                        $display("FAIL R3: message symbol actual=%02h expected=%02h", sym_out, e.sym);
                    end
                end else begin
                    last_par[par_cnt] = sym_out;
                    par_cnt++;
                    if (par_cnt == NP) begin
                        check_syndromes();
                        cw.delete();
                        par_cnt = 0;
                        blocks_done++;
                    end
                end
            end
        end else if (rst_seen) begin
            checks++;
            if (sym_out !== prev_out) begin
                errors++;
                $display("FAIL R6: output moved while disabled actual=%02h expected=%02h", sym_out, prev_out);
            end
        end
        prev_out = sym_out;
    end

    task automatic drive(input logic en, input logic ab, input logic [7:0] d, input logic is_par);
        exp_t item;
        @(negedge clk);
        clk_en = en;
        absorb = ab;
        sym_in = d;
        item.is_par = is_par;
        item.sym    = d;
        if (en) exp_q.push_back(item);
    endtask

    task automatic idle(input int n);
        repeat (n) drive(1'b0, 1'b0, 8'h5A, 1'b0);
    endtask

    task automatic run_block(input int k, input int seed, input bit gaps, input bit zeros);
        for (int i = 0; i < k; i++) begin
            if (gaps && (i % 5 == 2)) drive(1'b0, 1'b1, 8'hA5, 1'b0);
            drive(1'b1, 1'b1, zeros ? 8'h00 : pat(i, seed), 1'b0);
        end
        for (int i = 0; i < NP; i++) begin
            if (gaps && (i == 7)) drive(1'b0, 1'b0, 8'h3C, 1'b0);
            drive(1'b1, 1'b0, 8'(i * 29 + seed + 1), 1'b1);
        end
    endtask

    task automatic compare_ref(input string tag);
        int bad;
        bad = -1;
        for (int i = 0; i < NP; i++) if (last_par[i] !== ref_par[i] && bad < 0) bad = i;
        checks++;
        if (bad >= 0) begin
            errors++;
            $display("FAIL %s: check symbol %0d actual=%02h expected=%02h", tag, bad, last_par[bad], ref_par[bad]);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++; errors++;
        $display("FAIL watchdog: run did not complete actual=hung expected=done");
        finish_run();
    end

    initial begin
        int zero_bad;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        checks++; // R7 reset state
        if (sym_out !== 8'h00) begin
            errors++;
            $display("FAIL R7: output after reset actual=%02h expected=00", sym_out);
        end
        rst_n = 1'b1;
        idle(2);

        // Reference block RS(204,188) without gaps.
        run_block(188, 1, 1'b0, 1'b0);
        idle(3);
        for (int i = 0; i < NP; i++) ref_par[i] = last_par[i];
        checks++; // R4 exactly one block of sixteen check symbols
        if (blocks_done != 1) begin
            errors++;
            $display("FAIL R4: blocks completed actual=%0d expected=1", blocks_done);
        end

        // Same message with enable gaps: R6.
        run_block(188, 1, 1'b1, 1'b0);
        idle(3);
        compare_ref("R6");

        // Back-to-back short, longest, then reference block: R8 R9 R5.
        run_block(5, 2, 1'b0, 1'b0);
        run_block(239, 3, 1'b0, 1'b0);
        run_block(188, 1, 1'b0, 1'b0);
        idle(3);
        compare_ref("R5 R9");

        // One-symbol message: R8.
        run_block(1, 4, 1'b0, 1'b0);
        idle(3);

        // All-zero message: R10.
        run_block(50, 0, 1'b0, 1'b1);
        idle(3);
        zero_bad = -1;
        for (int i = 0; i < NP; i++) if (last_par[i] !== 8'h00 && zero_bad < 0) zero_bad = i;
        checks++;
        if (zero_bad >= 0) begin
            errors++;
            $display("FAIL R10: check symbol %0d actual=%02h expected=00", zero_bad, last_par[zero_bad]);
        end

        // Reset in the middle of a block: R7.
        for (int i = 0; i < 20; i++) drive(1'b1, 1'b1, pat(i, 7), 1'b0);
        idle(1);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        checks++;
        if (sym_out !== 8'h00) begin
            errors++;
            $display("FAIL R7: output during mid-block reset actual=%02h expected=00", sym_out);
        end
        rst_n = 1'b1;
        idle(1);
        run_block(188, 1, 1'b0, 1'b0);
        idle(3);
        compare_ref("R7");

        checks++;
        if (blocks_done != 8 || exp_q.size() != 0) begin
            errors++;
            $display("FAIL R8: blocks completed actual=%0d expected=8, pending=%0d", blocks_done, exp_q.size());
        end

        finish_run();
    end

endmodule